// File: doc/BRIEF.md
# Boot Mode and Code Memory Overlay Controller

This block decides, once per reset, how a processor starts and how its code space is laid out. On the first clock edge after the active-low reset is released, it captures the external-access strap, the bus-width strap, a stored status byte, a stored boot vector and a three-pin force combination. From these it derives the start PC and PSW, and it sets or clears the boot-ROM enable. These captured values then hold until reset is asserted again. Software can still rewrite the boot-ROM enable through a single write strobe.

After capture, every code fetch address is decoded into one of three targets:
- the internal flash, which is split into five blocks of unequal size;
- a 2 KB boot ROM that overlays the top of the 64 KB internal space;
- the external bus.

The decoded target and the flash block index are registered, and they appear one clock after the address.

Top module: `boot_overlay_ctrl`

## Requirements
- R1: While rst_n is low, straps_valid, tgt_sel and start_pc are all 0. straps_valid rises at the first rising clock edge with rst_n high. Until then tgt_sel stays 3'b000.
- R2: ext_code_en reports the EA pin value captured at that edge. When it is 0, every fetch decodes to the external bus (tgt_sel = 3'b100) and flash_blk = 0.
- R3: When ext_code_en is 1, any fetch address above 0xFFFF (any of bits 19:16 set) decodes to the external bus (3'b100).
- R4: bus_16bit reports the BUSW pin captured at that edge: 0 means an 8-bit bus and 1 means a 16-bit bus.
- R5: A nonzero status byte of any value at the capture edge sets boot_en.
- R6: With a zero status byte, boot_en is set only when psen_n_pin = 0, ale_pin = 1 and ea_pin = 1 at the capture edge. Otherwise boot_en is cleared.
- R7: When boot_en is set at capture, start_pc and start_psw take the boot vector inputs. Otherwise both are 0x0000.
- R8: When boot_en = 1 and ext_code_en = 1, addresses 0xF800 to 0xFFFF decode to the boot ROM (tgt_sel = 3'b010) with flash_blk = 0.
- R9: Other internal addresses decode to flash (tgt_sel = 3'b001), with flash_blk as follows:
  - 0 for 0x0000 to 0x1FFF;
  - 1 for 0x2000 to 0x3FFF;
  - 2 for 0x4000 to 0x7FFF;
  - 3 for 0x8000 to 0xBFFF;
  - 4 for 0xC000 to 0xFFFF.
- R10: A cycle with sw_we = 1 after capture loads sw_wdata into boot_en at that edge. Clearing boot_en exposes 0xF800 to 0xFFFF as flash block 4.
- R11: After capture, ext_code_en, bus_16bit, start_pc and start_psw do not change while reset stays released, whatever the pins and status do.
- R12: tgt_sel and flash_blk reflect the fetch address present at the previous rising edge. A new address does not change them before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psen_n_pin | input | 1 | Program store enable pin level (active low) |
| ale_pin | input | 1 | Address latch enable pin level |
| ea_pin | input | 1 | External access strap |
| busw_pin | input | 1 | Bus-width strap |
| status_byte | input | 8 | Stored boot status byte |
| vec_pc | input | 16 | Stored boot vector PC |
| vec_psw | input | 16 | Stored boot vector PSW |
| sw_we | input | 1 | Software write strobe for boot enable |
| sw_wdata | input | 1 | Value written to boot enable |
| fetch_addr | input | 20 | Code fetch address |
| straps_valid | output | 1 | Capture has happened since reset |
| ext_code_en | output | 1 | Captured EA strap |
| bus_16bit | output | 1 | Captured bus-width strap |
| boot_en | output | 1 | Boot ROM overlay enable |
| start_pc | output | 16 | Execution start PC |
| start_psw | output | 16 | Execution start PSW |
| tgt_sel | output | 3 | One-hot target: bit0 flash, bit1 boot ROM, bit2 external |
| flash_blk | output | 3 | Flash block index, 0 when not flash |

## Verification
The captured straps, boot_en and start vector are due one edge after rst_n rises. The bench therefore releases reset on a falling edge and samples on the next falling edge. It also samples once just before the release to confirm that nothing was captured early. A boot_en write is due at the edge that takes the strobe, and a decoded target is due one edge after its address is driven. Each check samples on the falling edge that follows the edge where the result is due. One check probes 1 ns after a new address is driven, to confirm the previous decode still holds before the edge.

// File: rtl/boot_overlay_pkg.sv
package boot_overlay_pkg;

    localparam int PC_W   = 16;
    localparam int STAT_W = 8;

    typedef enum logic [2:0] {
        TGT_NONE  = 3'b000,
        TGT_FLASH = 3'b001,
        TGT_BOOT  = 3'b010,
        TGT_EXT   = 3'b100
    } tgt_e;

    typedef struct packed {
        logic            valid;
        logic            ea;
        logic            bus16;
        logic            boot_en;
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] psw;
    } strap_s;

    typedef struct packed {
        tgt_e       tgt;
        logic [2:0] blk;
    } dec_s;

endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import boot_overlay_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psen_n_pin,
    input  logic              ale_pin,
    input  logic              ea_pin,
    input  logic              busw_pin,
    input  logic [STAT_W-1:0] status_byte,
    input  logic [PC_W-1:0]   vec_pc,
    input  logic [PC_W-1:0]   vec_psw,
    input  logic              sw_we,
    input  logic              sw_wdata,
    output strap_s            strap
);

    strap_s st_d, st_q;
    logic   force_pins;
    logic   enter_boot;

    always_comb begin
        force_pins = !psen_n_pin && ale_pin && ea_pin;
        enter_boot = (status_byte != '0) || force_pins;
        st_d       = st_q;
        if (!st_q.valid) begin
            st_d.valid   = 1'b1;
            st_d.ea      = ea_pin;
            st_d.bus16   = busw_pin;
            st_d.boot_en = enter_boot;
            st_d.pc      = enter_boot ? vec_pc  : '0;
            st_d.psw     = enter_boot ? vec_psw : '0;
        end else if (sw_we) begin
            st_d.boot_en = sw_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strap = st_q;

    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && $past(st_q.valid)) |-> ($stable(st_q.ea) && $stable(st_q.bus16)
                                              && $stable(st_q.pc) && $stable(st_q.psw))); // R11
    AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.valid && status_byte == '0 && !(!psen_n_pin && ale_pin && ea_pin))
        |=> (st_q.pc == '0 && !st_q.boot_en)); // R7
    AST_STATUS_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.valid && status_byte != '0) |=> st_q.boot_en); // R5
    AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && sw_we) |=> (st_q.boot_en == $past(sw_wdata))); // R10

endmodule

// File: rtl/fetch_decode.sv
module fetch_decode
    import boot_overlay_pkg::*;
#(
    parameter int          ADDR_W    = 20,
    parameter int          INT_W     = 16,
    parameter int          SMALL_W   = 13,
    parameter int          NUM_SMALL = 2,
    parameter int          LARGE_W   = 14,
    parameter int          BOOT_W    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              ea,
    input  logic              boot_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        tgt_sel,
    output logic [2:0]        flash_blk
);

    localparam int SMALL_END = NUM_SMALL << SMALL_W;
    localparam logic [INT_W-BOOT_W-1:0] BOOT_TAG = '1;

    dec_s              dec_d, dec_q;
    logic              above_int;
    logic [INT_W-1:0]  low;
    logic [INT_W:0]    off;
    logic [INT_W:0]    idx;

    generate
        if (ADDR_W > INT_W) begin : g_upper
            assign above_int = |addr[ADDR_W-1:INT_W];
        end else begin : g_no_upper
            assign above_int = 1'b0;
        end
    endgenerate

    assign low = addr[INT_W-1:0];

    always_comb begin
        off   = '0;
        idx   = '0;
        dec_d = '{tgt: TGT_NONE, blk: 3'd0};
        if (valid) begin
            if (!ea || above_int) begin
                dec_d.tgt = TGT_EXT;
            end else if (boot_en && low[INT_W-1:BOOT_W] == BOOT_TAG) begin
                dec_d.tgt = TGT_BOOT;
            end else begin
                dec_d.tgt = TGT_FLASH;
                if ({1'b0, low} < (INT_W+1)'(SMALL_END)) begin
                    idx = {1'b0, low} >> SMALL_W;
                end else begin
                    off = {1'b0, low} - (INT_W+1)'(SMALL_END);
                    idx = (off >> LARGE_W) + (INT_W+1)'(NUM_SMALL);
                end
                dec_d.blk = idx[2:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '{tgt: TGT_NONE, blk: 3'd0};
        else        dec_q <= dec_d;
    end

    assign tgt_sel   = dec_q.tgt;
    assign flash_blk = dec_q.blk;

    AST_TGT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel)); // R12
    AST_EXT_NO_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ea) |=> (tgt_sel == TGT_EXT && flash_blk == 3'd0)); // R2
    AST_BOOT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ea && boot_en && !above_int && low[INT_W-1:BOOT_W] == BOOT_TAG)
        |=> (tgt_sel == TGT_BOOT)); // R8
    AST_BLK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel != TGT_FLASH) |-> (flash_blk == 3'd0)); // R9

endmodule

// File: rtl/boot_overlay_ctrl.sv
module boot_overlay_ctrl
    import boot_overlay_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psen_n_pin,
    input  logic              ale_pin,
    input  logic              ea_pin,
    input  logic              busw_pin,
    input  logic [7:0]        status_byte,
    input  logic [15:0]       vec_pc,
    input  logic [15:0]       vec_psw,
    input  logic              sw_we,
    input  logic              sw_wdata,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              straps_valid,
    output logic              ext_code_en,
    output logic              bus_16bit,
    output logic              boot_en,
    output logic [15:0]       start_pc,
    output logic [15:0]       start_psw,
    output logic [2:0]        tgt_sel,
    output logic [2:0]        flash_blk
);

    strap_s strap;

    strap_capture u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .psen_n_pin (psen_n_pin),
        .ale_pin    (ale_pin),
        .ea_pin     (ea_pin),
        .busw_pin   (busw_pin),
        .status_byte(status_byte),
        .vec_pc     (vec_pc),
        .vec_psw    (vec_psw),
        .sw_we      (sw_we),
        .sw_wdata   (sw_wdata),
        .strap      (strap)
    );

    fetch_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (strap.valid),
        .ea       (strap.ea),
        .boot_en  (strap.boot_en),
        .addr     (fetch_addr),
        .tgt_sel  (tgt_sel),
        .flash_blk(flash_blk)
    );

    assign straps_valid = strap.valid;
    assign ext_code_en  = strap.ea;
    assign bus_16bit    = strap.bus16;
    assign boot_en      = strap.boot_en;
    assign start_pc     = strap.pc;
    assign start_psw    = strap.psw;

    AST_NOTGT_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!straps_valid) |=> (tgt_sel == 3'b000)); // R1

endmodule

// File: tb/tb_boot_overlay_ctrl.sv
module tb_boot_overlay_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psen_n_pin = 1'b1, ale_pin = 1'b0, ea_pin = 1'b1, busw_pin = 1'b0;
    logic [7:0]  status_byte = '0;
    logic [15:0] vec_pc = '0, vec_psw = '0;
    logic        sw_we = 1'b0, sw_wdata = 1'b0;
    logic [19:0] fetch_addr = '0;
    logic        straps_valid, ext_code_en, bus_16bit, boot_en;
    logic [15:0] start_pc, start_psw;
    logic [2:0]  tgt_sel, flash_blk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic m_ea, m_bus, m_boot;
    logic [15:0] m_pc, m_psw;

    always #4 clk = ~clk;

    boot_overlay_ctrl dut (
        .clk(clk), .rst_n(rst_n), .psen_n_pin(psen_n_pin), .ale_pin(ale_pin),
        .ea_pin(ea_pin), .busw_pin(busw_pin), .status_byte(status_byte),
        .vec_pc(vec_pc), .vec_psw(vec_psw), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .fetch_addr(fetch_addr), .straps_valid(straps_valid), .ext_code_en(ext_code_en),
        .bus_16bit(bus_16bit), .boot_en(boot_en), .start_pc(start_pc),
        .start_psw(start_psw), .tgt_sel(tgt_sel), .flash_blk(flash_blk)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_dec(logic [19:0] a, logic ea, logic ben);
        logic [15:0] l = a[15:0];
        if (!ea || a[19:16] != 4'h0) return {3'b100, 3'd0};
        if (ben && l >= 16'hF800)    return {3'b010, 3'd0};
        if (l < 16'h2000) return {3'b001, 3'd0};
        if (l < 16'h4000) return {3'b001, 3'd1};
        if (l < 16'h8000) return {3'b001, 3'd2};
        if (l < 16'hC000) return {3'b001, 3'd3};
        return {3'b001, 3'd4};
    endfunction

    task automatic do_reset(logic pn, logic al, logic ea, logic bw, logic [7:0] st,
                            logic [15:0] pc, logic [15:0] psw);
        @(negedge clk);
        rst_n = 1'b0;
        psen_n_pin = pn; ale_pin = al; ea_pin = ea; busw_pin = bw;
        status_byte = st; vec_pc = pc; vec_psw = psw;
        repeat (2) @(negedge clk);
        chk("R1 valid low in reset", {31'd0, straps_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        m_ea   = ea;
        m_bus  = bw;
        m_boot = (st != 8'd0) || (!pn && al && ea);
        m_pc   = m_boot ? pc : 16'h0000;
        m_psw  = m_boot ? psw : 16'h0000;
        chk("R1 valid after release", {31'd0, straps_valid}, 32'd1);
        chk("R2 ea latched", {31'd0, ext_code_en}, {31'd0, m_ea});
        chk("R4 busw latched", {31'd0, bus_16bit}, {31'd0, m_bus});
        chk(st != 8'd0 ? "R5 boot by status" : "R6 boot by pins", {31'd0, boot_en}, {31'd0, m_boot});
        chk("R7 start pc", {16'd0, start_pc}, {16'd0, m_pc});
        chk("R7 start psw", {16'd0, start_psw}, {16'd0, m_psw});
        psen_n_pin = ~pn; ale_pin = ~al; ea_pin = ~ea; busw_pin = ~bw;
        status_byte = ~st; vec_pc = ~pc; vec_psw = ~psw;
        repeat (2) @(negedge clk);
        chk("R11 straps hold", {12'd0, ext_code_en, bus_16bit, start_pc, start_psw[1:0]},
            {12'd0, m_ea, m_bus, m_pc, m_psw[1:0]});
        chk("R11 psw hold", {16'd0, start_psw}, {16'd0, m_psw});
    endtask

    task automatic fetch(logic [19:0] a);
        logic [5:0] e;
        string tag;
        @(negedge clk);
        fetch_addr = a;
        @(negedge clk);
        e = exp_dec(a, m_ea, m_boot);
        if (!m_ea)              tag = "R2 ext fetch";
        else if (e[5])          tag = "R3 above internal";
        else if (e[4])          tag = "R8 boot window";
        else                    tag = "R9 flash block";
        chk(tag, {26'd0, tgt_sel, flash_blk}, {26'd0, e});
    endtask

    task automatic sw_write(logic v);
        @(negedge clk);
        sw_we = 1'b1; sw_wdata = v;
        @(negedge clk);
        sw_we = 1'b0;
        m_boot = v;
        chk("R10 sw write", {31'd0, boot_en}, {31'd0, v});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [19:0] edges [12];
        edges = '{20'h00000, 20'h01FFF, 20'h02000, 20'h03FFF, 20'h04000, 20'h07FFF,
                  20'h08000, 20'h0BFFF, 20'h0C000, 20'h0F7FF, 20'h0F800, 20'h10000};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset valid", {31'd0, straps_valid}, 32'd0);
        chk("R1 reset tgt", {29'd0, tgt_sel}, 32'd0);
        chk("R1 reset pc", {16'd0, start_pc}, 32'd0);

        // plain start, internal code, no boot
        do_reset(1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 16'hF800, 16'h8000);
        foreach (edges[i]) fetch(edges[i]);
        // status nonzero
        do_reset(1'b1, 1'b0, 1'b1, 1'b1, 8'h80, 16'hF800, 16'h8000);
        foreach (edges[i]) fetch(edges[i]);
        fetch(20'h0FFFF);
        // R12: new address has no effect before the next edge
        @(negedge clk); fetch_addr = 20'h00100;
        @(negedge clk); fetch_addr = 20'h0F900;
        #1 chk("R12 old decode held", {26'd0, tgt_sel, flash_blk}, {26'd0, 3'b001, 3'd0});
        @(negedge clk);
        chk("R12 new decode", {26'd0, tgt_sel, flash_blk}, {26'd0, 3'b010, 3'd0});
        // software clears then sets
        sw_write(1'b0);
        fetch(20'h0F900);
        sw_write(1'b1);
        fetch(20'h0FFFF);
        // pin force with zero status
        do_reset(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 16'h1234, 16'h5678);
        fetch(20'h0F800);
        // pin force fails with EA low
        do_reset(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 16'h1234, 16'h5678);
        foreach (edges[i]) fetch(edges[i]);

        for (int t = 0; t < 16; t++) begin
            logic [7:0] st = ($urandom % 2) ? 8'h00 : 8'($urandom);
            do_reset(1'($urandom), 1'($urandom), ($urandom % 4) != 0, 1'($urandom),
                     st, 16'($urandom), 16'($urandom));
            for (int k = 0; k < 24; k++) begin
                case ($urandom % 3)
                    0: fetch(edges[$urandom % 12] + 20'($urandom % 2));
                    1: fetch({4'h0, 16'($urandom)});
                    default: fetch(20'($urandom));
                endcase
                if (k == 12 && ($urandom % 2)) sw_write(1'($urandom));
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule